// File: doc/BRIEF.md
# PLL Lock Status Detector

This block decides whether a clock synthesizer's PLL has reached frequency lock and reports the result on a lock pin and on a status bit that software reads. Both outputs come from one state register, so they always change in the same cycle. The block is clocked by the feedback-derived clock. The reference clock arrives asynchronously. It passes through a two-flop synchronizer with rising-edge detection before anything counts it.

The feedback clock goes through a prescaler that divides it by the programmed feedback-to-reference ratio. A measurement window lasts a fixed number of reference edges. At the end of each window, the number of prescaler wraps is compared against the number of reference edges. A match within one edge counts as a raw lock. A passing window starts a qualification hold-off, and the lock outputs rise only after the hold-off completes.

Any of the following sends the detector back to the unlocked state:
- a failing window;
- a run of feedback cycles with no reference edge;
- a divider-change pulse;
- a frequency step command.

The detector then tries to acquire lock again by itself. All pins are plain control and status levels or pulses. No data flows through the block, so it has no valid/ready handshake.

Top module: `pll_lock_monitor`

## Requirements
- R1: `lock_pin` and `lock_stat` are equal in every cycle.
- R2: While `rst` is high, both lock outputs are 0 and the detector returns to the unlocked state with all counters cleared.
- R3: The reference input is counted only through a two-flop synchronizer with rising-edge detection. Each synchronized edge is a single-cycle pulse, and a reference high time of one feedback cycle is enough to be counted.
- R4: A window spans WIN_EDGES (64) synchronized reference edges. The window passes when the number of wraps of a divide-by-`fb_ratio` feedback prescaler in that window lies in WIN_EDGES-1 to WIN_EDGES+1.
- R5: After a passing window, the lock outputs stay 0 until HOLD_EDGES (256) more reference edges have been counted. Lock therefore cannot appear before WIN_EDGES+HOLD_EDGES reference edges after reset or after any unlock.
- R6: Once the feedback cycles counted since the last synchronized reference edge reach 2×`fb_ratio`, lock is cleared and the windows are held in restart.
- R7: A one-cycle `div_change` pulse clears lock on the next clock edge and restarts the window and the hold-off.
- R8: A one-cycle `step_cmd` pulse clears lock on the next clock edge and restarts the window and the hold-off.
- R9: After any loss of lock, the detector acquires and asserts lock again without any input other than a valid reference.
- R10: A reference that drifts slowly enough for each window to stay within tolerance does not drop lock. For example, one period stretched by one feedback cycle in every 64 periods must not drop lock.
- R11: A reference whose rate differs from feedback/`fb_ratio` by more than the tolerance never reaches lock. If the rate moves outside the tolerance while locked, lock drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Feedback-derived clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_clk_in | input | 1 | Asynchronous reference clock |
| fb_ratio | input | RATIO_W | Feedback cycles per reference period, at least 1 |
| div_change | input | 1 | Pulse when the feedback or pre-divider is reprogrammed |
| step_cmd | input | 1 | Pulse on a frequency decrement or increment command |
| lock_pin | output | 1 | Lock indication to the package pin |
| lock_stat | output | 1 | Lock status bit for register readback |

## Verification
Some properties are checked by assertions in every cycle:
- a synchronized edge is never two cycles wide;
- a window never both passes and fails;
- lock is cleared in the cycle after any unlock cause or control pulse;
- lock only rises out of the qualifying state, with its hold-off counter at the final count.

Other behaviours need whole scenarios, which only the bench's sweeps can show:
- the arithmetic of the hold-off delay across several ratios;
- failure to lock on mismatched rates;
- lock held through slow drift;
- recovery after the reference is removed and restored.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;
  typedef enum logic [1:0] {
    ST_UNLOCKED = 2'd0,
    ST_QUALIFY  = 2'd1,
    ST_LOCKED   = 2'd2
  } lock_state_e;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic ref_async,
  output logic ref_rise
);
  logic [2:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 3'b000;
    else     sync_q <= {sync_q[1:0], ref_async};
  end

  assign ref_rise = sync_q[1] & ~sync_q[2];

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ref_rise |=> !ref_rise);
endmodule

// File: rtl/freq_window_cmp.sv
module freq_window_cmp #(
  parameter int RATIO_W   = 8,
  parameter int WIN_EDGES = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ref_rise,
  output logic               win_pass,
  output logic               win_fail
);
  localparam int WIN_W  = $clog2(WIN_EDGES);
  localparam int FB_MAX = 2 * WIN_EDGES + 2;
  localparam int FB_W   = $clog2(FB_MAX + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_EDGES - 1);
  localparam logic [FB_W-1:0]  FB_SAT   = FB_W'(FB_MAX);
  localparam logic [FB_W:0]    TOL_LO   = (FB_W + 1)'(WIN_EDGES - 1);
  localparam logic [FB_W:0]    TOL_HI   = (FB_W + 1)'(WIN_EDGES + 1);

  logic [RATIO_W-1:0] pre_cnt;
  logic [WIN_W-1:0]   win_cnt;
  logic [FB_W-1:0]    fb_cnt;
  logic [FB_W:0]      fb_total;
  logic               wrap, win_end, in_tol;

  assign wrap     = ({1'b0, pre_cnt} + 1'b1) >= {1'b0, ratio};
  assign fb_total = {1'b0, fb_cnt} + {{FB_W{1'b0}}, wrap};
  assign win_end  = ref_rise && (win_cnt == WIN_LAST);
  assign in_tol   = (fb_total >= TOL_LO) && (fb_total <= TOL_HI);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre_cnt  <= '0;
      win_cnt  <= '0;
      fb_cnt   <= '0;
      win_pass <= 1'b0;
      win_fail <= 1'b0;
    end else begin
      pre_cnt  <= wrap ? '0 : pre_cnt + 1'b1;
      win_pass <= win_end && in_tol;
      win_fail <= win_end && !in_tol;
      if (win_end) begin
        win_cnt <= '0;
        fb_cnt  <= '0;
      end else begin
        if (ref_rise) win_cnt <= win_cnt + 1'b1;
        if (wrap && fb_cnt != FB_SAT) fb_cnt <= fb_cnt + 1'b1;
      end
    end
  end

  // R4
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(win_pass && win_fail));

  // R4
  verdict_on_edge_chk: assert property (@(posedge clk) disable iff (rst || restart)
    (win_pass || win_fail) |-> $past(ref_rise));
endmodule

// File: rtl/miss_edge_timer.sv
module miss_edge_timer #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ref_rise,
  output logic               miss
);
  localparam int CW = RATIO_W + 2;

  logic [CW-1:0] gap_cnt;
  logic [CW-1:0] limit;

  assign limit = {1'b0, ratio, 1'b0};
  assign miss  = gap_cnt >= limit;

  always_ff @(posedge clk) begin
    if (rst)                  gap_cnt <= '0;
    else if (ref_rise)        gap_cnt <= '0;
    else if (gap_cnt < limit) gap_cnt <= gap_cnt + 1'b1;
  end

  // R6
  edge_clears_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_rise && ratio != '0 && $stable(ratio)) |=> !miss);
endmodule

// File: rtl/lock_qual_fsm.sv
module lock_qual_fsm
  import pll_lock_pkg::*;
#(
  parameter int HOLD_EDGES = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic win_pass,
  input  logic ref_rise,
  output logic locked
);
  localparam int HOLD_W = $clog2(HOLD_EDGES);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_EDGES - 1);

  lock_state_e      state;
  logic [HOLD_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      state    <= ST_UNLOCKED;
      hold_cnt <= '0;
    end else begin
      unique case (state)
        ST_UNLOCKED: begin
          hold_cnt <= '0;
          if (win_pass) state <= ST_QUALIFY;
        end
        ST_QUALIFY: begin
          if (ref_rise) begin
            if (hold_cnt == HOLD_LAST) state <= ST_LOCKED;
            else                       hold_cnt <= hold_cnt + 1'b1;
          end
        end
        ST_LOCKED: state <= ST_LOCKED;
        default:   state <= ST_UNLOCKED;
      endcase
    end
  end

  assign locked = (state == ST_LOCKED);

  // R6
  kill_drops_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> !locked);

  // R5
  hold_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> ($past(state) == ST_QUALIFY && $past(hold_cnt) == HOLD_LAST));

  // R5
  no_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UNLOCKED) |=> (state != ST_LOCKED));
endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int RATIO_W    = 8,
  parameter int WIN_EDGES  = 64,
  parameter int HOLD_EDGES = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_clk_in,
  input  logic [RATIO_W-1:0] fb_ratio,
  input  logic               div_change,
  input  logic               step_cmd,
  output logic               lock_pin,
  output logic               lock_stat
);
  logic ref_rise, miss, win_pass, win_fail, restart, kill, locked;

  assign restart = div_change | step_cmd | miss;
  assign kill    = restart | win_fail;

  ref_edge_sync u_sync (
    .clk       (clk),
    .rst       (rst),
    .ref_async (ref_clk_in),
    .ref_rise  (ref_rise)
  );

  freq_window_cmp #(.RATIO_W(RATIO_W), .WIN_EDGES(WIN_EDGES)) u_win (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .ratio    (fb_ratio),
    .ref_rise (ref_rise),
    .win_pass (win_pass),
    .win_fail (win_fail)
  );

  miss_edge_timer #(.RATIO_W(RATIO_W)) u_miss (
    .clk      (clk),
    .rst      (rst),
    .ratio    (fb_ratio),
    .ref_rise (ref_rise),
    .miss     (miss)
  );

  lock_qual_fsm #(.HOLD_EDGES(HOLD_EDGES)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .kill     (kill),
    .win_pass (win_pass),
    .ref_rise (ref_rise),
    .locked   (locked)
  );

  assign lock_pin  = locked;
  assign lock_stat = locked;

  // R7 R8
  ctrl_pulse_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (div_change || step_cmd) |=> !lock_pin);

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !lock_pin && !lock_stat);
endmodule

// File: tb/pll_lock_monitor_tb.sv
module pll_lock_monitor_tb;
  localparam int RATIO_W = 8;
  localparam int WIN     = 64;
  localparam int HOLD    = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic div_change = 1'b0;
  logic step_cmd = 1'b0;
  logic [RATIO_W-1:0] fb_ratio = 8'd4;
  logic lock_pin, lock_stat;

  int checks = 0;
  int errors = 0;
  int per = 4;
  bit ref_en = 1'b0;
  bit drift = 1'b0;
  int ph = 0;
  int pidx = 0;
  int cur = 4;
  int edge_cnt = 0;
  int hi_cnt = 0;
  int drop_cnt = 0;
  int mism_cnt = 0;
  logic prev_lock = 1'b0;

  always #2 clk = ~clk;

  pll_lock_monitor #(.RATIO_W(RATIO_W), .WIN_EDGES(WIN), .HOLD_EDGES(HOLD)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .ref_clk_in (ref_in),
    .fb_ratio   (fb_ratio),
    .div_change (div_change),
    .step_cmd   (step_cmd),
    .lock_pin   (lock_pin),
    .lock_stat  (lock_stat)
  );

  // reference stimulus: period per, optionally one period stretched every 64
  always @(negedge clk) begin
    if (!ref_en) begin
      ref_in <= 1'b0;
      ph = 0;
      cur = per;
    end else begin
      if (ph == 0) begin
        ref_in   <= 1'b1;
        edge_cnt <= edge_cnt + 1;
      end else if (ph >= cur / 2) begin
        ref_in <= 1'b0;
      end
      ph = ph + 1;
      if (ph >= cur) begin
        ph = 0;
        pidx = pidx + 1;
        cur = (drift && (pidx % 64 == 0)) ? per + 1 : per;
      end
    end
  end

  always @(negedge clk) begin
    if (lock_pin) hi_cnt <= hi_cnt + 1;
    if (prev_lock && !lock_pin) drop_cnt <= drop_cnt + 1;
    if (lock_pin !== lock_stat) mism_cnt <= mism_cnt + 1;
    prev_lock <= lock_pin;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_edges(input int n);
    int b = edge_cnt;
    while (edge_cnt - b < n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int r, input int p);
    @(negedge clk);
    rst = 1'b1;
    ref_en = 1'b0;
    drift = 1'b0;
    fb_ratio = RATIO_W'(r);
    per = p;
    cycles(3);
    check(lock_pin == 1'b0 && lock_stat == 1'b0, "R2", int'(lock_pin), 0);
    rst = 1'b0;
    ref_en = 1'b1;
  endtask

  task automatic pulse_ctrl(input bit which);
    if (which) step_cmd = 1'b1; else div_change = 1'b1;
    @(negedge clk);
    step_cmd = 1'b0;
    div_change = 1'b0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(4 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int lh;
    int dr;
    cycles(4);

    // sweep of matched ratios: hold-off and lock arrival
    for (int r = 2; r <= 5; r++) begin
      do_reset(r, r);
      lh = hi_cnt;
      wait_edges(WIN + HOLD - 4);
      check(hi_cnt == lh, "R5", hi_cnt - lh, 0);
      wait_edges(WIN + 8);
      check(lock_pin == 1'b1, (r == 2) ? "R3" : "R4", int'(lock_pin), 1);
      check(lock_stat == 1'b1, "R1", int'(lock_stat), 1);
    end

    // reference removed while locked (ratio 5)
    check(lock_pin == 1'b1, "R6", int'(lock_pin), 1);
    ref_en = 1'b0;
    cycles(2 * 5 + 8);
    check(lock_pin == 1'b0, "R6", int'(lock_pin), 0);
    ref_en = 1'b1;
    wait_edges(2 * WIN + HOLD + 8);
    check(lock_pin == 1'b1, "R9", int'(lock_pin), 1);

    // divider change with new ratio 4
    @(negedge clk);
    fb_ratio = 8'd4;
    per = 4;
    pulse_ctrl(1'b0);
    check(lock_pin == 1'b0, "R7", int'(lock_pin), 0);
    lh = hi_cnt;
    wait_edges(WIN + HOLD - 4);
    check(hi_cnt == lh, "R7", hi_cnt - lh, 0);
    wait_edges(WIN + 12);
    check(lock_pin == 1'b1, "R9", int'(lock_pin), 1);

    // step command
    @(negedge clk);
    pulse_ctrl(1'b1);
    check(lock_pin == 1'b0, "R8", int'(lock_pin), 0);
    wait_edges(2 * WIN + HOLD + 8);
    check(lock_pin == 1'b1, "R8", int'(lock_pin), 1);

    // slow drift inside tolerance
    dr = drop_cnt;
    drift = 1'b1;
    wait_edges(4 * WIN);
    check(drop_cnt == dr, "R10", drop_cnt - dr, 0);
    check(lock_pin == 1'b1, "R10", int'(lock_pin), 1);
    drift = 1'b0;

    // rate moves out of tolerance while locked
    per = 6;
    wait_edges(2 * WIN + 4);
    check(lock_pin == 1'b0, "R11", int'(lock_pin), 0);

    // mismatched rates never lock
    do_reset(4, 5);
    lh = hi_cnt;
    wait_edges(3 * WIN + HOLD);
    check(hi_cnt == lh, "R11", hi_cnt - lh, 0);
    do_reset(3, 2);
    lh = hi_cnt;
    wait_edges(3 * WIN + HOLD);
    check(hi_cnt == lh, "R11", hi_cnt - lh, 0);

    check(mism_cnt == 0, "R1", mism_cnt, 0);
    summary();
    $finish;
  end
endmodule